// File: doc/BRIEF.md
# Burst Write to Dword Register Splitter

This block sits between the write side of a bus target and a bank of 32-bit memory-mapped registers. A write burst is announced by a command that carries the dword address of the first dword and the burst length, written as the number of dwords minus one. The payload then arrives as 64-bit beats, each with eight byte enables. The block turns the burst into single 32-bit register writes, one per dword, in ascending address order, with each dword's byte enables kept. The result is the same as issuing the dwords one by one as separate writes.

A burst may start on any dword. Within a beat, the dword whose address is even travels in bits 31:0 and the odd one in bits 63:32. If a burst starts on an odd dword, the first beat carries only its upper half. If it ends on an even dword, the last beat carries only its lower half. While a beat holding two of the burst's dwords is split into two writes, the beat handshake is held off for one cycle. The register bank is a plain array that sits at a fixed window of dword addresses and has a combinational read port.

Top module: `burst_dword_splitter`

## Requirements
- R1: Every dword of an accepted burst of N = cmd_dwm1+1 dwords starting at dword address A is assigned address A+k, for k = 0..N-1. When it has a non-zero byte enable, it comes out as exactly one write on rw_* with that address. The writes come out in the order of k, and rw_en goes high one cycle after the beat lane is taken.
- R2: A dword with even address takes its data from beat_data[31:0] and its enables from beat_be[3:0]. An odd dword takes beat_data[63:32] and beat_be[7:4]. A burst that starts on an odd address uses only the upper half of its first beat. A burst that ends on an even address uses only the lower half of its last beat.
- R3: A beat that carries two dwords of the burst sees beat_ready low in its first cycle and high in its second. A beat that carries one dword sees beat_ready high in its first cycle.
- R4: A dword whose four byte enables are all zero produces no write, but it still uses up its address slot. The register it maps to keeps its value.
- R5: After a write, the register holds the written data in the bytes whose enable is set and its old value in the other bytes, the same as a separate dword write.
- R6: Two writes on consecutive cycles have addresses that differ by exactly +1.
- R7: cmd_ready is high only when no burst is in progress. It stays low from the command's acceptance until the last dword has been taken. In the cycle the last beat is accepted, a new command may be presented, and it is accepted at the next edge.
- R8: The bank holds REG_COUNT registers at dword addresses BANK_BASE_DW to BANK_BASE_DW+REG_COUNT-1. Writes outside that window are dropped, and a read outside it returns zero.
- R9: After reset all registers read zero, cmd_ready is high, beat_ready is low and rw_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Burst command present |
| cmd_ready | output | 1 | Splitter idle, command accepted |
| cmd_dwaddr | input | DWA_W | Dword address of the first dword |
| cmd_dwm1 | input | LEN_W | Burst length in dwords minus one |
| beat_valid | input | 1 | Payload beat present; held until accepted |
| beat_ready | output | 1 | Beat fully consumed this cycle |
| beat_data | input | 64 | Beat payload, even dword low, odd dword high |
| beat_be | input | 8 | Byte enables of the beat |
| rw_en | output | 1 | Register write strobe |
| rw_addr | output | DWA_W | Dword address of the write |
| rw_data | output | 32 | Write data |
| rw_be | output | 4 | Write byte enables |
| rd_addr | input | DWA_W | Dword address for readback |
| rd_data | output | 32 | Register contents, zero outside the window |

## Verification
The write of a burst's final dword and the acceptance of the next burst's command can fall in the same cycle. So can the bank update of that dword and the load of the new start address. The bench provokes this by presenting the next command immediately after the previous burst's last beat is accepted. The writes of both bursts are then matched in order against the reference queue, and the full register window is read back against the byte-level model.

// File: rtl/bws_pkg.sv
package bws_pkg;
  localparam int BEAT_W  = 64;
  localparam int WORD_W  = 32;
  localparam int WBE_W   = WORD_W / 8;
  localparam int BBE_W   = BEAT_W / 8;

  // A beat is finished once its odd lane or the final dword is taken.
  function automatic logic closes_beat(input logic ptr_odd, input logic final_dw);
    return ptr_odd || final_dw;
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(input logic [BEAT_W-1:0] d,
                                                  input logic hi);
    return hi ? d[BEAT_W-1:WORD_W] : d[WORD_W-1:0];
  endfunction

  function automatic logic [WBE_W-1:0] pick_be(input logic [BBE_W-1:0] be,
                                               input logic hi);
    return hi ? be[BBE_W-1:WBE_W] : be[WBE_W-1:0];
  endfunction

  function automatic logic in_window(input int unsigned a,
                                     input int unsigned base,
                                     input int unsigned nregs);
    return (a >= base) && (a < base + nregs);
  endfunction
endpackage

// File: rtl/bws_tracker.sv
module bws_tracker #(
  parameter int DWA_W = 14,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DWA_W-1:0] load_ptr,
  input  logic [LEN_W-1:0] load_dwm1,
  input  logic             step,
  output logic             active,
  output logic [DWA_W-1:0] ptr,
  output logic             last_dw
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      left <= '0;
    end else if (load) begin
      ptr  <= load_ptr;
      left <= CNT_W'(load_dwm1) + CNT_W'(1);
    end else if (step && active) begin
      ptr  <= ptr + DWA_W'(1);
      left <= left - CNT_W'(1);
    end
  end

  assign active  = (left != '0);
  assign last_dw = (left == CNT_W'(1));

  // R7: a new burst is never loaded over one still in progress
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active);

  // R1: a burst only finishes by taking its final dword
  a_r1_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(last_dw) && $past(step)));
endmodule

// File: rtl/bws_lane.sv
module bws_lane
  import bws_pkg::*;
#(
  parameter int DWA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              hi,
  input  logic [DWA_W-1:0]  dw_addr,
  input  logic [BEAT_W-1:0] beat_data,
  input  logic [BBE_W-1:0]  beat_be,
  output logic              rw_en,
  output logic [DWA_W-1:0]  rw_addr,
  output logic [WORD_W-1:0] rw_data,
  output logic [WBE_W-1:0]  rw_be
);
  logic [WBE_W-1:0]  lane_be;
  logic [WORD_W-1:0] lane_word;
  logic              issue;

  assign lane_be   = pick_be(beat_be, hi);
  assign lane_word = pick_word(beat_data, hi);
  assign issue     = fire && (lane_be != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rw_en   <= 1'b0;
      rw_addr <= '0;
      rw_data <= '0;
      rw_be   <= '0;
    end else begin
      rw_en <= issue;
      if (issue) begin
        rw_addr <= dw_addr;
        rw_data <= lane_word;
        rw_be   <= lane_be;
      end
    end
  end

  // R4: no write strobe carries an empty byte mask
  a_r4_no_empty_write: assert property (@(posedge clk) disable iff (!rst_n)
    rw_en |-> (rw_be != '0));

  // R6: back-to-back writes step upward by one dword
  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_en && $past(rw_en)) |-> (rw_addr == $past(rw_addr) + DWA_W'(1)));
endmodule

// File: rtl/bws_regbank.sv
module bws_regbank
  import bws_pkg::*;
#(
  parameter int          DWA_W        = 14,
  parameter int          REG_COUNT    = 64,
  parameter int unsigned BANK_BASE_DW = 32'hA00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DWA_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WBE_W-1:0]  wr_be,
  input  logic [DWA_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam logic [DWA_W-1:0] BASE = DWA_W'(BANK_BASE_DW);

  logic [WORD_W-1:0] regs [REG_COUNT];
  logic              wr_hit, rd_hit;
  logic [IDX_W-1:0]  widx, ridx;
  logic [WORD_W-1:0] cur, merged;

  assign wr_hit = in_window(32'(wr_addr), BANK_BASE_DW, REG_COUNT);
  assign rd_hit = in_window(32'(rd_addr), BANK_BASE_DW, REG_COUNT);
  assign widx   = IDX_W'(wr_addr - BASE);
  assign ridx   = IDX_W'(rd_addr - BASE);
  assign cur    = wr_hit ? regs[widx] : '0;

  for (genvar b = 0; b < WBE_W; b++) begin : g_byte
    assign merged[8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : cur[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else if (wr_en && wr_hit) begin
      regs[widx] <= merged;
    end
  end

  assign rd_data = rd_hit ? regs[ridx] : '0;

  // R5: a full-mask write lands whole in its register
  a_r5_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit && (wr_be == 4'hF)) |=> (regs[$past(widx)] == $past(wr_data)));

  // R5: a byte without enable keeps its old value
  a_r5_masked_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit && !wr_be[0]) |=> (regs[$past(widx)][7:0] == $past(cur[7:0])));
endmodule

// File: rtl/burst_dword_splitter.sv
module burst_dword_splitter
  import bws_pkg::*;
#(
  parameter int          DWA_W        = 14,
  parameter int          LEN_W        = 8,
  parameter int          REG_COUNT    = 64,
  parameter int unsigned BANK_BASE_DW = 32'hA00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DWA_W-1:0]  cmd_dwaddr,
  input  logic [LEN_W-1:0]  cmd_dwm1,
  input  logic              beat_valid,
  output logic              beat_ready,
  input  logic [63:0]       beat_data,
  input  logic [7:0]        beat_be,
  output logic              rw_en,
  output logic [DWA_W-1:0]  rw_addr,
  output logic [31:0]       rw_data,
  output logic [3:0]        rw_be,
  input  logic [DWA_W-1:0]  rd_addr,
  output logic [31:0]       rd_data
);
  logic             active, last_dw, load, fire;
  logic [DWA_W-1:0] ptr;

  assign cmd_ready  = !active;
  assign load       = cmd_valid && cmd_ready;
  assign fire       = active && beat_valid;
  assign beat_ready = active && closes_beat(ptr[0], last_dw);

  bws_tracker #(.DWA_W(DWA_W), .LEN_W(LEN_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .load(load), .load_ptr(cmd_dwaddr),
    .load_dwm1(cmd_dwm1), .step(fire), .active(active), .ptr(ptr),
    .last_dw(last_dw)
  );

  bws_lane #(.DWA_W(DWA_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .fire(fire), .hi(ptr[0]), .dw_addr(ptr),
    .beat_data(beat_data), .beat_be(beat_be), .rw_en(rw_en),
    .rw_addr(rw_addr), .rw_data(rw_data), .rw_be(rw_be)
  );

  bws_regbank #(.DWA_W(DWA_W), .REG_COUNT(REG_COUNT),
                .BANK_BASE_DW(BANK_BASE_DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(rw_en), .wr_addr(rw_addr),
    .wr_data(rw_data), .wr_be(rw_be), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R3: a stalled beat is stalled for one cycle at most
  a_r3_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready && active) |=> (beat_ready || !beat_valid));
endmodule

// File: tb/burst_dword_splitter_test.sv
`timescale 1ns/1ps
module burst_dword_splitter_test;
  localparam int BASE_DW = 32'hA00;
  localparam int NREG    = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [13:0] cmd_dwaddr;
  logic [7:0]  cmd_dwm1;
  logic        beat_valid;
  logic        beat_ready;
  logic [63:0] beat_data;
  logic [7:0]  beat_be;
  logic        rw_en;
  logic [13:0] rw_addr;
  logic [31:0] rw_data;
  logic [3:0]  rw_be;
  logic [13:0] rd_addr;
  logic [31:0] rd_data;

  always #2 clk = ~clk;

  burst_dword_splitter uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dwaddr(cmd_dwaddr), .cmd_dwm1(cmd_dwm1), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .beat_data(beat_data), .beat_be(beat_be),
    .rw_en(rw_en), .rw_addr(rw_addr), .rw_data(rw_data), .rw_be(rw_be),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct {
    int          addr;
    logic [31:0] data;
    logic [3:0]  be;
  } wr_t;

  wr_t         expq[$];
  logic [31:0] model[NREG];
  int          nchk = 0;
  int          nfail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference comparison of every write strobe, checked each clock
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rw_en === 1'b1) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4", "unexpected write addr", 64'(rw_addr), 64'(0));
      end else begin
        wr_t e;
        e = expq.pop_front();
        chk(rw_addr == 14'(e.addr), "R1", "write addr", 64'(rw_addr), 64'(e.addr));
        chk(rw_data == e.data, "R2", "write data", 64'(rw_data), 64'(e.data));
        chk(rw_be == e.be, "R2", "write be", 64'(rw_be), 64'(e.be));
      end
    end
  end

  task automatic readback_all();
    for (int i = 0; i < NREG; i++) begin
      rd_addr = 14'(BASE_DW + i);
      #0.02;
      chk(rd_data == model[i], "R5", "register readback", 64'(rd_data), 64'(model[i]));
    end
  endtask

  task automatic run_burst(input int sbyte, input int ndw, input int mode,
                           input int gap, input bit tight, input bit drain);
    int sdw = sbyte >> 2;
    int edw = sdw + ndw - 1;
    int q0  = sdw >> 1;
    int q1  = edw >> 1;
    logic [63:0] bd[$];
    logic [7:0]  bb[$];
    int          nl[$];
    for (int q = q0; q <= q1; q++) begin
      logic [63:0] d;
      logic [7:0]  b;
      int          lanes = 0;
      d = {$urandom(), $urandom()};
      case (mode)
        1:       b = 8'($urandom());
        2:       b = 8'hF0;
        default: b = 8'hFF;
      endcase
      for (int h = 0; h < 2; h++) begin
        int dw = q * 2 + h;
        if (dw >= sdw && dw <= edw) begin
          logic [31:0] w;
          logic [3:0]  e;
          lanes++;
          w = h ? d[63:32] : d[31:0];
          e = h ? b[7:4] : b[3:0];
          if (e != 4'h0) begin
            wr_t x;
            x.addr = dw; x.data = w; x.be = e;
            expq.push_back(x);
            if (dw >= BASE_DW && dw < BASE_DW + NREG) begin
              for (int k = 0; k < 4; k++)
                if (e[k]) model[dw - BASE_DW][8*k +: 8] = w[8*k +: 8];
            end
          end
        end
      end
      bd.push_back(d); bb.push_back(b); nl.push_back(lanes);
    end
    if (!tight) begin
      @(posedge clk); #1;
    end
    cmd_valid  = 1'b1;
    cmd_dwaddr = 14'(sdw);
    cmd_dwm1   = 8'(ndw - 1);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    for (int i = 0; i < bd.size(); i++) begin
      int cyc = 0;
      beat_valid = 1'b1;
      beat_data  = bd[i];
      beat_be    = bb[i];
      forever begin
        @(negedge clk);
        cyc++;
        if (i == 0 && cyc == 1)
          chk(cmd_ready == 1'b0, "R7", "cmd_ready while busy", 64'(cmd_ready), 64'(0));
        if (beat_ready || cyc >= 4) break;
      end
      chk(cyc == nl[i], "R3", "cycles to accept beat", 64'(cyc), 64'(nl[i]));
      @(posedge clk); #1;
      beat_valid = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1;
      end
    end
    if (drain) begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(expq.size() == 0, "R1", "writes missing", 64'(expq.size()), 64'(0));
      chk(cmd_ready == 1'b1, "R7", "cmd_ready after burst", 64'(cmd_ready), 64'(1));
      readback_all();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_dwaddr = '0; cmd_dwm1 = '0;
    beat_valid = 1'b0; beat_data = '0; beat_be = '0; rd_addr = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(cmd_ready == 1'b1, "R9", "cmd_ready", 64'(cmd_ready), 64'(1));
    chk(beat_ready == 1'b0, "R9", "beat_ready", 64'(beat_ready), 64'(0));
    chk(rw_en == 1'b0, "R9", "rw_en", 64'(rw_en), 64'(0));
    readback_all();

    // R1: 16-byte burst at 0x2800 touches all four registers
    run_burst(32'h2800, 4, 0, 0, 1'b0, 1'b1);
    // R2: odd start, upper half only in first beat, lower only in last
    run_burst(32'h2804, 4, 0, 1, 1'b0, 1'b1);
    // R2: single dwords in each lane
    run_burst(32'h280C, 1, 0, 0, 1'b0, 1'b1);
    run_burst(32'h2810, 1, 0, 0, 1'b0, 1'b1);
    // R5: random byte enables, partial bytes merge
    run_burst(32'h2820, 7, 1, 0, 1'b0, 1'b1);
    run_burst(32'h2824, 9, 1, 1, 1'b0, 1'b1);
    // R4: lower lanes masked off keep earlier contents
    run_burst(32'h2840, 6, 0, 0, 1'b0, 1'b1);
    run_burst(32'h2840, 6, 2, 0, 1'b0, 1'b1);
    // R8: bursts straddling both window edges
    run_burst(32'h27F8, 4, 0, 0, 1'b0, 1'b1);
    run_burst(32'h28F8, 4, 0, 0, 1'b0, 1'b1);
    rd_addr = 14'(32'h27F8 >> 2); #0.02;
    chk(rd_data == 32'h0, "R8", "read below window", 64'(rd_data), 64'(0));
    rd_addr = 14'(32'h2900 >> 2); #0.02;
    chk(rd_data == 32'h0, "R8", "read above window", 64'(rd_data), 64'(0));
    // R7: next command presented as the last beat is taken
    run_burst(32'h2880, 3, 0, 0, 1'b0, 1'b0);
    run_burst(32'h2890, 5, 0, 0, 1'b1, 1'b0);
    run_burst(32'h28A4, 2, 1, 0, 1'b1, 1'b1);
    // R6: long odd-start burst with idle gaps
    run_burst(32'h2884, 40, 0, 2, 1'b0, 1'b1);
    run_burst(32'h2800, 64, 1, 0, 1'b0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule